// File: doc/BRIEF.md
# PS/2 Host Register Interface

This block is the register front end of a PS/2 keyboard or mouse port. It sits on a simple 32-bit register bus addressed by byte offset. Each access is one cycle long, and read data is combinational during that cycle. The front end holds a control word, a clock divisor word and a last-received-byte holder. It exposes a status word, a data port and an interrupt status word, and it reads back a fixed eight-byte identification block at the top of its 4 KiB window.

On the device side, received bytes arrive over a valid/ready byte stream, and the block holds at most one unread byte at a time. Bytes written to the data port leave as a one-cycle transmit strobe that carries the byte. A single level interrupt combines a receive interrupt enable, gated by the pending flag, with a transmit interrupt enable that asserts the line on its own, because the transmitter is always reported empty. The line serializer that drives the PS/2 clock and data pins is a separate block.

Top module: `ps2_host_regs`

## Requirements
- R1: Registers are selected by word index, which is the byte offset shifted right by two: index 0 is control, 1 is status, 2 is data, 3 is clock divisor and 4 is interrupt status. Control and clock divisor read back the full 32-bit word last written to them.
- R2: A read at byte offsets 0xFE0 to 0xFFC, one byte per word, returns in bits 7:0 the bytes 0x50, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in ascending address order. Bits 31:8 read as 0.
- R3: The status word has bit 6 = 1 (transmit empty), bit 4 = receive pending, and bit 2 = XOR of all eight bits of the last byte taken from the data port. All other bits read as 0.
- R4: `irq_o` equals (pending AND control bit 4) OR control bit 3.
- R5: A data read while a byte is pending returns that byte, stores it as the last byte and clears pending. A data read with nothing pending returns the last byte again.
- R6: The interrupt status word reads with bit 0 = pending, bit 1 = 1, and all other bits 0.
- R7: A control write changes `irq_o` from the clock edge that ends the write cycle.
- R8: A write to the data port raises `tx_stb_o` for exactly one cycle, the cycle after the write, with `tx_data_o` equal to bits 7:0 of the written word.
- R9: Reads at undefined offsets (word index 5 and up, below 0xFE0) return 0. Writes there, and writes to the status, interrupt status and identification words, change no state.
- R10: `rx_ready_o` is high exactly when no byte is pending. A byte is captured when `rx_valid_i` and `rx_ready_o` are both high, and pending is then set. While pending, `rx_valid_i` is ignored.
- R11: After reset, control, clock divisor, last byte and pending are all 0, `irq_o` is 0 and `tx_stb_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Bus access in this cycle |
| we_i | input | 1 | Access is a write |
| addr_i | input | 12 | Byte offset in the window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid during a read access |
| irq_o | output | 1 | Level interrupt |
| rx_valid_i | input | 1 | Received byte offered |
| rx_data_i | input | 8 | Received byte |
| rx_ready_o | output | 1 | Receive holder free |
| tx_stb_o | output | 1 | Transmit byte strobe |
| tx_data_o | output | 8 | Transmit byte |

## Verification
The assertions assume the bus holds `sel_i`, `we_i`, `addr_i` and `wdata_i` steady through each cycle and changes them only away from the sampling edge. They also assume the device side may offer a byte at any time, including while one is already pending. The stimulus drives every input on the falling edge and offers receive bytes with no regard to `rx_ready_o`, so the ignore path is exercised. Random accesses mix defined registers, identification words and undefined offsets, so decode is exercised across the whole window.

// File: rtl/ps2_reg_pkg.sv
package ps2_reg_pkg;
  typedef enum logic [2:0] {
    REG_CTRL  = 3'd0,
    REG_STAT  = 3'd1,
    REG_DATA  = 3'd2,
    REG_CDIV  = 3'd3,
    REG_ISTAT = 3'd4
  } reg_idx_e;

  localparam int STAT_TXE_BIT  = 6;
  localparam int STAT_RXF_BIT  = 4;
  localparam int STAT_PAR_BIT  = 2;
  localparam int CTRL_RXIE_BIT = 4;
  localparam int CTRL_TXIE_BIT = 3;
  localparam int ID_BYTES      = 8;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0: id_byte = 8'h50;
      3'd1: id_byte = 8'h10;
      3'd2: id_byte = 8'h04;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/ps2_rx_hold.sv
module ps2_rx_hold #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [BYTE_W-1:0] rx_data_i,
  output logic              rx_ready_o,
  input  logic              consume_i,
  output logic              pending_o,
  output logic [BYTE_W-1:0] rd_byte_o,
  output logic              last_par_o
);
  logic [BYTE_W-1:0] buf_q, last_q;
  logic              pend_q;

  assign rx_ready_o = ~pend_q;
  assign pending_o  = pend_q;
  assign rd_byte_o  = pend_q ? buf_q : last_q;
  assign last_par_o = ^last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q  <= '0;
      last_q <= '0;
      pend_q <= 1'b0;
    end else if (pend_q) begin
      if (consume_i) begin
        last_q <= buf_q;
        pend_q <= 1'b0;
      end
    end else if (rx_valid_i) begin
      buf_q  <= rx_data_i;
      pend_q <= 1'b1;
    end
  end
endmodule

// File: rtl/ps2_irq_gen.sv
module ps2_irq_gen (
  input  logic pending_i,
  input  logic rx_ie_i,
  input  logic tx_ie_i,
  output logic irq_o
);
  // transmitter is always empty, so its enable alone raises the line
  assign irq_o = (pending_i & rx_ie_i) | tx_ie_i;
endmodule

// File: rtl/ps2_tx_strobe.sv
module ps2_tx_strobe #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              send_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              stb_o,
  output logic [BYTE_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_o  <= 1'b0;
      data_o <= '0;
    end else begin
      stb_o <= send_i;
      if (send_i) data_o <= byte_i;
    end
  end
endmodule

// File: rtl/ps2_host_regs.sv
module ps2_host_regs
  import ps2_reg_pkg::*;
#(
  parameter int AW     = 12,
  parameter int DW     = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              irq_o,
  input  logic              rx_valid_i,
  input  logic [BYTE_W-1:0] rx_data_i,
  output logic              rx_ready_o,
  output logic              tx_stb_o,
  output logic [BYTE_W-1:0] tx_data_o
);
  localparam int WAW = AW - 2;
  localparam logic [AW-1:0] ID_BASE = AW'((1 << AW) - 4 * ID_BYTES);

  logic [WAW-1:0] word;
  logic           is_id, rd, wr;
  logic           hit_ctrl, hit_stat, hit_data, hit_cdiv, hit_istat;
  logic [DW-1:0]  ctrl_q, cdiv_q;
  logic           pending, last_par;
  logic [BYTE_W-1:0] rd_byte;

  assign word      = addr_i[AW-1:2];
  assign is_id     = addr_i >= ID_BASE;
  assign rd        = sel_i & ~we_i;
  assign wr        = sel_i & we_i;
  assign hit_ctrl  = word == WAW'(REG_CTRL);
  assign hit_stat  = word == WAW'(REG_STAT);
  assign hit_data  = word == WAW'(REG_DATA);
  assign hit_cdiv  = word == WAW'(REG_CDIV);
  assign hit_istat = word == WAW'(REG_ISTAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      cdiv_q <= '0;
    end else if (wr) begin
      if (hit_ctrl) ctrl_q <= wdata_i;
      if (hit_cdiv) cdiv_q <= wdata_i;
    end
  end

  ps2_rx_hold #(.BYTE_W(BYTE_W)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_valid_i (rx_valid_i),
    .rx_data_i  (rx_data_i),
    .rx_ready_o (rx_ready_o),
    .consume_i  (rd & hit_data),
    .pending_o  (pending),
    .rd_byte_o  (rd_byte),
    .last_par_o (last_par)
  );

  ps2_irq_gen u_irq (
    .pending_i (pending),
    .rx_ie_i   (ctrl_q[CTRL_RXIE_BIT]),
    .tx_ie_i   (ctrl_q[CTRL_TXIE_BIT]),
    .irq_o     (irq_o)
  );

  ps2_tx_strobe #(.BYTE_W(BYTE_W)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .send_i (wr & hit_data),
    .byte_i (wdata_i[BYTE_W-1:0]),
    .stb_o  (tx_stb_o),
    .data_o (tx_data_o)
  );

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      if (is_id) begin
        rdata_o[7:0] = id_byte(addr_i[4:2]);
      end else if (hit_ctrl) begin
        rdata_o = ctrl_q;
      end else if (hit_stat) begin
        rdata_o[STAT_TXE_BIT] = 1'b1;
        rdata_o[STAT_RXF_BIT] = pending;
        rdata_o[STAT_PAR_BIT] = last_par;
      end else if (hit_data) begin
        rdata_o[BYTE_W-1:0] = rd_byte;
      end else if (hit_cdiv) begin
        rdata_o = cdiv_q;
      end else if (hit_istat) begin
        rdata_o[1:0] = {1'b1, pending};
      end
    end
  end
endmodule

// File: rtl/ps2_host_regs_chk.sv
module ps2_host_regs_chk #(
  parameter int AW     = 12,
  parameter int DW     = 32,
  parameter int BYTE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_i,
  input logic              we_i,
  input logic [AW-1:0]     addr_i,
  input logic [DW-1:0]     wdata_i,
  input logic [DW-1:0]     rdata_o,
  input logic              irq_o,
  input logic              rx_valid_i,
  input logic              rx_ready_o,
  input logic              tx_stb_o,
  input logic [BYTE_W-1:0] tx_data_o
);
  logic [AW-3:0] w;
  logic data_wr, rd;
  assign w       = addr_i[AW-1:2];
  assign rd      = sel_i && !we_i;
  assign data_wr = sel_i && we_i && w == (AW-2)'(2);

  AST_TX_FOLLOWS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_wr |=> tx_stb_o && tx_data_o == $past(wdata_i[BYTE_W-1:0])); // R8
  AST_TX_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_wr |=> !tx_stb_o); // R8
  AST_RX_TAKE_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i && rx_ready_o |=> !rx_ready_o); // R10
  AST_STATUS_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd && w == (AW-2)'(1) |-> rdata_o[6] && rdata_o[4] == !rx_ready_o
      && (rdata_o & ~DW'(32'h54)) == '0); // R3
  AST_ISTAT_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd && w == (AW-2)'(4) |-> rdata_o == DW'({1'b1, !rx_ready_o})); // R6
  AST_ID_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd && addr_i >= AW'((1 << AW) - 32) |-> rdata_o[DW-1:8] == '0); // R2
  AST_IRQ_IDLE_RX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd && w == (AW-2)'(2) && !rx_ready_o && !irq_o |=> !irq_o); // R4
endmodule

bind ps2_host_regs ps2_host_regs_chk #(.AW(AW), .DW(DW), .BYTE_W(BYTE_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sel_i      (sel_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .irq_o      (irq_o),
  .rx_valid_i (rx_valid_i),
  .rx_ready_o (rx_ready_o),
  .tx_stb_o   (tx_stb_o),
  .tx_data_o  (tx_data_o)
);

// File: tb/ps2_host_regs_test.sv
module ps2_host_regs_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sel_i = 1'b0, we_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o, rx_ready_o, tx_stb_o;
  logic        rx_valid_i = 1'b0;
  logic [7:0]  rx_data_i = '0, tx_data_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // bench model of the register state
  logic [31:0] m_ctrl = '0, m_cdiv = '0;
  logic [7:0]  m_last = '0, m_buf = '0;
  logic        m_pend = 1'b0;

  ps2_host_regs uut (.*);

  always #10 clk_i = ~clk_i;

  function automatic logic exp_irq();
    return (m_pend & m_ctrl[4]) | m_ctrl[3];
  endfunction
  function automatic logic [31:0] exp_stat();
    return 32'h40 | (32'(m_pend) << 4) | (32'(^m_last) << 2);
  endfunction
  function automatic logic [7:0] exp_id(input int i);
    logic [7:0] t [8] = '{8'h50, 8'h10, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    return t[i];
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    logic is_data;
    is_data = a[11:2] == 10'd2;
    @(negedge clk_i);
    sel_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    if (a[11:2] == 10'd0) m_ctrl = d;
    if (a[11:2] == 10'd3) m_cdiv = d;
    @(negedge clk_i);
    sel_i = 0; we_i = 0;
    if (is_data) begin
      check("R8 strobe", 32'(tx_stb_o), 32'd1);
      check("R8 byte", 32'(tx_data_o), 32'(d[7:0]));
      @(negedge clk_i);
      check("R8 single", 32'(tx_stb_o), 32'd0);
    end
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk_i);
    sel_i = 1; we_i = 0; addr_i = a;
    #1 d = rdata_o;
    @(posedge clk_i);
    if (a[11:2] == 10'd2 && m_pend) begin
      m_last = m_buf; m_pend = 0;
    end
    @(negedge clk_i);
    sel_i = 0;
  endtask

  task automatic rx_push(input logic [7:0] b);
    @(negedge clk_i);
    check("R10 ready", 32'(rx_ready_o), 32'(!m_pend));
    rx_valid_i = 1; rx_data_i = b;
    @(posedge clk_i);
    if (!m_pend) begin m_buf = b; m_pend = 1; end
    @(negedge clk_i);
    rx_valid_i = 0;
  endtask

  task automatic read_check(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    bus_read(a, d);
    check(req, d, exp);
  endtask

  task automatic data_read_check();
    logic [31:0] d, e;
    e = {24'h0, m_pend ? m_buf : m_last};
    bus_read(12'h008, d);
    check("R5 data read", d, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    // R11 reset state
    check("R11 irq", 32'(irq_o), 0);
    check("R11 tx", 32'(tx_stb_o), 0);
    check("R11 ready", 32'(rx_ready_o), 1);
    rst_ni = 1;
    read_check("R11 ctrl", 12'h000, 0);
    read_check("R11 cdiv", 12'h00C, 0);
    read_check("R11 data", 12'h008, 0);
    read_check("R3 status reset", 12'h004, 32'h40);
    read_check("R6 istat reset", 12'h010, 32'h2);

    // R2 identification block
    for (int i = 0; i < 8; i++) read_check("R2 id", 12'hFE0 + 12'(4 * i), 32'(exp_id(i)));

    // R1 storage
    bus_write(12'h000, 32'hA5A5_0000);
    read_check("R1 ctrl", 12'h000, 32'hA5A5_0000);
    bus_write(12'h00C, 32'h1234_5678);
    read_check("R1 cdiv", 12'h00C, 32'h1234_5678);

    // R3 parity: odd weight then even weight
    rx_push(8'h01);
    data_read_check();
    read_check("R3 parity odd", 12'h004, 32'h44);
    rx_push(8'h03);
    read_check("R3 status pending", 12'h004, 32'h54);
    read_check("R6 istat pending", 12'h010, 32'h3);
    rx_push(8'hEE);  // R10 ignored while pending
    data_read_check();
    check("R10 kept byte", 32'(m_last), 32'h03);
    read_check("R3 parity even", 12'h004, 32'h40);
    data_read_check();  // R5 repeat read

    // R4/R7 every combination of control bits 3 and 4, pending off and on
    for (int p = 0; p < 2; p++) begin
      if (p == 1) rx_push(8'h5A);
      for (int c = 0; c < 4; c++) begin
        bus_write(12'h000, 32'(c) << 3);
        check("R7 irq after ctrl write", 32'(irq_o), 32'(exp_irq()));
      end
    end
    data_read_check();
    check("R4 irq after consume", 32'(irq_o), 32'(exp_irq()));

    // R9 undefined offsets and read-only words
    bus_write(12'h014, 32'hFFFF_FFFF);
    bus_write(12'h800, 32'hFFFF_FFFF);
    bus_write(12'h004, 32'hFFFF_FFFF);
    bus_write(12'h010, 32'hFFFF_FFFF);
    bus_write(12'hFE0, 32'hFFFF_FFFF);
    read_check("R9 undef read", 12'h014, 0);
    read_check("R9 undef read hi", 12'h800, 0);
    read_check("R9 ctrl kept", 12'h000, m_ctrl);
    read_check("R9 cdiv kept", 12'h00C, m_cdiv);
    read_check("R9 status kept", 12'h004, exp_stat());

    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [31:0] r;
      r = $urandom;
      case (r % 9)
        0: bus_write(12'h000, $urandom & 32'h18);
        1: read_check("R3 status", 12'h004, exp_stat());
        2: rx_push(8'($urandom));
        3: data_read_check();
        4: bus_write(12'h008, $urandom);
        5: begin bus_write(12'h00C, $urandom); read_check("R1 cdiv", 12'h00C, m_cdiv); end
        6: read_check("R6 istat", 12'h010, 32'h2 | 32'(m_pend));
        7: read_check("R9 undef", 12'(20 + 4 * ($urandom % 1000)), 0);
        default: begin
          int i;
          i = int'($urandom % 8);
          read_check("R2 id", 12'hFE0 + 12'(4 * i), 32'(exp_id(i)));
        end
      endcase
      check("R4 irq", 32'(irq_o), 32'(exp_irq()));
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule